// File: doc/BRIEF.md
# Overlapping Speech Frame Windower

This block accepts a stream of signed 12-bit speech samples (nominally 8 kHz, one per strobe) and keeps them in a circular sample store. It slices the stream into analysis frames of 200 samples. A new frame is opened after every 80 further samples, so neighbouring frames share 120 samples.

Each frame is read back oldest sample first. Every sample is multiplied by its Hamming weight, and the results leave as a serial stream with first and last markers, ready for a transform stage. Emission runs at one sample per clock. A whole frame therefore drains in about 200 clocks, which is far inside the 80-sample hop. Each incoming sample is emitted in up to three frames.

A frame-ready pulse marks every frame boundary. If a boundary arrives while the previous frame is still being read out, that frame is dropped and an overrun pulse is raised. A boundary that lands exactly on the readout's final cycle is still accepted, so two frames can be emitted back to back.

Top module: `frame_windower`

## Requirements
- R1: While reset is asserted and right after it is released, `o_valid`, `o_first`, `o_last`, `o_frame_rdy` and `o_overrun` are 0.
- R2: No frame boundary occurs before 200 samples have been accepted. `o_frame_rdy` goes high for one cycle right after the clock edge that accepts the 200th sample.
- R3: After the first boundary, a further boundary occurs on every 80th accepted sample. The frame at boundary f holds accepted samples 80f to 80f+199, counted from 0 since reset, and is emitted oldest first.
- R4: Output sample n of a frame is round-half-up(x·h[n]/2^7), where h[n] = round(65536·(0.54 − 0.46·cos(2πn/199))) and x is the signed input sample. `o_data` is a signed two's-complement value in units of 2^-9 (15 integer bits, 9 fractional bits).
- R5: An accepted frame is emitted as 200 samples on consecutive cycles. `o_valid` for sample 0 is first high two clock edges after the edge that accepted the completing sample.
- R6: `o_first` is high only with sample 0 of a frame and `o_last` only with sample 199. Both are high only while `o_valid` is high.
- R7: If a boundary occurs while a frame is being read and the reader is not on its final issue cycle, `o_overrun` pulses for one cycle together with `o_frame_rdy`. The new frame is not emitted. Later boundaries are handled normally.
- R8: A boundary on the reader's final issue cycle is accepted with no overrun. Its sample 0 follows the previous frame's sample 199 on the very next cycle.
- R9: Cycles with `i_valid` low neither count as samples nor change the frame contents, whatever `i_sample` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| i_valid | input | 1 | Sample strobe, one sample per high cycle |
| i_sample | input | 12 | Signed input sample |
| o_valid | output | 1 | Windowed sample valid |
| o_first | output | 1 | Marks sample 0 of a frame |
| o_last | output | 1 | Marks sample 199 of a frame |
| o_data | output | 24 | Windowed sample, signed, 9 fractional bits |
| o_frame_rdy | output | 1 | One-cycle pulse at each frame boundary |
| o_overrun | output | 1 | One-cycle pulse when a boundary is dropped because the reader is busy |

## Verification
A new frame boundary and the final issue of the frame being read can fall in the same cycle. The bench provokes this by sending 200 samples and then 79 more back to back, holding the strobe low for exactly 120 cycles, and then sending the 80th sample. That makes the boundary land 200 edges after the first one. The pass condition is no overrun and 400 emitted samples, with sample 0 of the second frame on the cycle right after sample 199 of the first. The same run with 119 idle cycles instead must produce an overrun and only one emitted frame.

// File: rtl/fw_pkg.sv
package fw_pkg;

  typedef struct packed {
    logic first;
    logic last;
  } fw_tag_t;

  // Hamming weight 0.54 - 0.46*cos(2*pi*n/(len-1)) as an unsigned fixed-point
  // integer with 'frac' fractional bits. Cosine is evaluated by a Taylor
  // series in Q28 integer arithmetic, after folding the angle into [0, pi/2].
  function automatic longint hamming_coef(input int n, input int len, input int frac);
    longint one;
    longint pi_q;
    longint x;
    longint x2;
    longint term;
    longint sum;
    longint c;
    longint num;
    longint den;
    logic   neg;
    one  = 64'sd1 <<< 28;
    pi_q = 64'sd843314857;
    x    = (2 * pi_q * longint'(n)) / longint'(len - 1);
    if (x > pi_q) x = 2 * pi_q - x;
    neg = 1'b0;
    if (2 * x > pi_q) begin
      x   = pi_q - x;
      neg = 1'b1;
    end
    x2   = (x * x) >>> 28;
    term = one;
    sum  = one;
    for (int k = 1; k <= 10; k++) begin
      term = -(((term * x2) >>> 28) / longint'((2 * k - 1) * (2 * k)));
      sum  = sum + term;
    end
    c   = neg ? -sum : sum;
    num = 54 * one - 46 * c;
    den = 100 * (one >>> frac);
    return (num + den / 2) / den;
  endfunction

endpackage

// File: rtl/fw_rst_sync.sv
module fw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/fw_sample_ring.sv
module fw_sample_ring #(
  parameter int SAMPLE_W = 12,
  parameter int DEPTH    = 512,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SAMPLE_W-1:0] wr_data,
  input  logic                rd_en,
  input  logic [AW-1:0]       rd_addr,
  output logic [AW-1:0]       wr_ptr,
  output logic [SAMPLE_W-1:0] rd_data
);
  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [AW-1:0]       wr_ptr_d;

  // Next-state: the pointer advances only on an accepted sample (R9).
  always_comb begin
    wr_ptr_d = wr_ptr;
    if (wr_en) wr_ptr_d = wr_ptr + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_ptr <= '0;
    else        wr_ptr <= wr_ptr_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/fw_frame_sched.sv
module fw_frame_sched #(
  parameter int FRAME_LEN = 200,
  parameter int HOP       = 80,
  localparam int CW       = $clog2(FRAME_LEN)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en,
  output logic frame_go
);
  logic [CW-1:0] left_q;
  logic [CW-1:0] left_d;

  // R2/R3: count down a full frame first, then one hop per boundary.
  assign frame_go = smp_en && (left_q == '0);

  always_comb begin
    left_d = left_q;
    if (smp_en) begin
      if (left_q == '0) left_d = CW'(HOP - 1);
      else              left_d = left_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= CW'(FRAME_LEN - 1);
    else        left_q <= left_d;
  end
endmodule

// File: rtl/fw_frame_reader.sv
module fw_frame_reader
  import fw_pkg::*;
#(
  parameter int FRAME_LEN = 200,
  parameter int AW        = 9,
  localparam int IW       = $clog2(FRAME_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_go,
  input  logic [AW-1:0] wr_ptr,
  output logic          issue_en,
  output logic [AW-1:0] issue_addr,
  output logic [IW-1:0] issue_idx,
  output fw_tag_t       issue_tag,
  output logic          frame_rdy,
  output logic          overrun
);
  localparam logic [IW-1:0] LAST = IW'(FRAME_LEN - 1);

  logic          run_q, run_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [AW-1:0] base_q, base_d;
  logic          rdy_d, ovr_d;
  logic          at_last;
  logic          accept;

  assign at_last    = run_q && (idx_q == LAST);
  // R8: the final issue cycle frees the reader for a new frame.
  assign accept     = frame_go && (!run_q || at_last);
  assign issue_en   = run_q;
  assign issue_idx  = idx_q;
  assign issue_addr = base_q + AW'(idx_q);
  assign issue_tag  = '{first: (idx_q == '0), last: (idx_q == LAST)};

  always_comb begin
    run_d  = run_q;
    idx_d  = idx_q;
    base_d = base_q;
    if (accept) begin
      run_d  = 1'b1;
      idx_d  = '0;
      // The completing sample is written this cycle at wr_ptr (R3).
      base_d = wr_ptr - AW'(FRAME_LEN - 1);
    end else if (run_q) begin
      if (at_last) run_d = 1'b0;
      else         idx_d = idx_q + IW'(1);
    end
    rdy_d = frame_go;
    ovr_d = frame_go && !accept;   // R7
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      idx_q     <= '0;
      base_q    <= '0;
      frame_rdy <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      run_q     <= run_d;
      idx_q     <= idx_d;
      base_q    <= base_d;
      frame_rdy <= rdy_d;
      overrun   <= ovr_d;
    end
  end
endmodule

// File: rtl/fw_coef_rom.sv
module fw_coef_rom #(
  parameter int FRAME_LEN = 200,
  parameter int COEF_W    = 16,
  localparam int IW       = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IW-1:0]     rd_idx,
  output logic [COEF_W-1:0] coef
);
  logic [COEF_W-1:0] tab [FRAME_LEN];

  // R4: table entries are computed from the window formula at elaboration.
  for (genvar g = 0; g < FRAME_LEN; g++) begin : g_tab
    assign tab[g] = COEF_W'(fw_pkg::hamming_coef(g, FRAME_LEN, COEF_W));
  end

  always_ff @(posedge clk) begin
    if (rd_en) coef <= tab[rd_idx];
  end
endmodule

// File: rtl/fw_window_mul.sv
module fw_window_mul
  import fw_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int COEF_W    = 16,
  parameter int OUT_W     = 24,
  parameter int OUT_FRAC  = 9,
  localparam int SHIFT    = COEF_W - OUT_FRAC,
  localparam int PW       = SAMPLE_W + COEF_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                issue_en,
  input  fw_tag_t             issue_tag,
  input  logic [SAMPLE_W-1:0] smp,
  input  logic [COEF_W-1:0]   coef,
  output logic                o_valid,
  output logic                o_first,
  output logic                o_last,
  output logic [OUT_W-1:0]    o_data
);
  logic              s1_vld_q;
  fw_tag_t           s1_tag_q;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] rnd;
  logic [OUT_W-1:0]  data_d;
  logic              vld_d, first_d, last_d;

  // Stage 1 tracks the ring and table read that issue in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q <= 1'b0;
      s1_tag_q <= '0;
    end else begin
      s1_vld_q <= issue_en;
      if (issue_en) s1_tag_q <= issue_tag;
    end
  end

  // R4: signed sample times unsigned weight, rounded half up to OUT_FRAC bits.
  assign prod = PW'($signed(smp)) * $signed({1'b0, coef});
  assign rnd  = prod + PW'(1 <<< (SHIFT - 1));

  always_comb begin
    vld_d   = s1_vld_q;
    first_d = s1_vld_q && s1_tag_q.first;
    last_d  = s1_vld_q && s1_tag_q.last;
    data_d  = o_data;
    if (s1_vld_q) data_d = OUT_W'(rnd >>> SHIFT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_first <= 1'b0;
      o_last  <= 1'b0;
      o_data  <= '0;
    end else begin
      o_valid <= vld_d;
      o_first <= first_d;
      o_last  <= last_d;
      o_data  <= data_d;
    end
  end
endmodule

// File: rtl/frame_windower.sv
module frame_windower
  import fw_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int FRAME_LEN = 200,
  parameter int HOP       = 80,
  parameter int BUF_DEPTH = 512,
  parameter int COEF_W    = 16,
  parameter int OUT_INT   = 15,
  parameter int OUT_FRAC  = 9,
  localparam int OUT_W    = OUT_INT + OUT_FRAC,
  localparam int AW       = $clog2(BUF_DEPTH),
  localparam int IW       = $clog2(FRAME_LEN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                i_valid,
  input  logic [SAMPLE_W-1:0] i_sample,
  output logic                o_valid,
  output logic                o_first,
  output logic                o_last,
  output logic [OUT_W-1:0]    o_data,
  output logic                o_frame_rdy,
  output logic                o_overrun
);
  logic                rst_int_n;
  logic                smp_en;
  logic                frame_go;
  logic [AW-1:0]       wr_ptr;
  logic                issue_en;
  logic [AW-1:0]       issue_addr;
  logic [IW-1:0]       issue_idx;
  fw_tag_t             issue_tag;
  logic [SAMPLE_W-1:0] ring_q;
  logic [COEF_W-1:0]   coef_q;

  assign smp_en = i_valid;

  fw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  fw_sample_ring #(.SAMPLE_W(SAMPLE_W), .DEPTH(BUF_DEPTH)) u_ring (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (smp_en),
    .wr_data (i_sample),
    .rd_en   (issue_en),
    .rd_addr (issue_addr),
    .wr_ptr  (wr_ptr),
    .rd_data (ring_q)
  );

  fw_frame_sched #(.FRAME_LEN(FRAME_LEN), .HOP(HOP)) u_sched (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .smp_en   (smp_en),
    .frame_go (frame_go)
  );

  fw_frame_reader #(.FRAME_LEN(FRAME_LEN), .AW(AW)) u_reader (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .frame_go   (frame_go),
    .wr_ptr     (wr_ptr),
    .issue_en   (issue_en),
    .issue_addr (issue_addr),
    .issue_idx  (issue_idx),
    .issue_tag  (issue_tag),
    .frame_rdy  (o_frame_rdy),
    .overrun    (o_overrun)
  );

  fw_coef_rom #(.FRAME_LEN(FRAME_LEN), .COEF_W(COEF_W)) u_rom (
    .clk    (clk),
    .rd_en  (issue_en),
    .rd_idx (issue_idx),
    .coef   (coef_q)
  );

  fw_window_mul #(
    .SAMPLE_W (SAMPLE_W),
    .COEF_W   (COEF_W),
    .OUT_W    (OUT_W),
    .OUT_FRAC (OUT_FRAC)
  ) u_mul (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .issue_en  (issue_en),
    .issue_tag (issue_tag),
    .smp       (ring_q),
    .coef      (coef_q),
    .o_valid   (o_valid),
    .o_first   (o_first),
    .o_last    (o_last),
    .o_data    (o_data)
  );
endmodule

// File: rtl/fw_checker.sv
module fw_checker #(
  parameter int FRAME_LEN = 200,
  localparam int CW       = $clog2(FRAME_LEN + 1)
) (
  input logic clk,
  input logic rst_n,
  input logic i_valid,
  input logic o_valid,
  input logic o_first,
  input logic o_last,
  input logic o_frame_rdy,
  input logic o_overrun
);
  logic [CW-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     seen_q <= '0;
    else if (i_valid && (seen_q != CW'(FRAME_LEN))) seen_q <= seen_q + CW'(1);
  end

  a_r2_no_early_frame: assert property (@(posedge clk) disable iff (!rst_n)
    o_frame_rdy |-> (seen_q == CW'(FRAME_LEN)));

  a_r5_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_last) |=> (o_valid && !o_first));

  a_r5_first_latency: assert property (@(posedge clk) disable iff (!rst_n)
    o_first |-> ($past(o_frame_rdy, 2) && !$past(o_overrun, 2)));

  a_r6_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (o_first || o_last) |-> (o_valid && !(o_first && o_last)));

  a_r8_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_last) |=> (!o_valid || o_first));

  a_r7_overrun_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    o_overrun |-> o_frame_rdy);
endmodule

bind frame_windower fw_checker #(.FRAME_LEN(FRAME_LEN)) u_fw_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .i_valid     (i_valid),
  .o_valid     (o_valid),
  .o_first     (o_first),
  .o_last      (o_last),
  .o_frame_rdy (o_frame_rdy),
  .o_overrun   (o_overrun)
);

// File: tb/tb_frame_windower.sv
`timescale 1ns/1ps
module tb_frame_windower;
  logic        clk;
  logic        rst_n;
  logic        i_valid;
  logic [11:0] i_sample;
  logic        o_valid, o_first, o_last, o_frame_rdy, o_overrun;
  logic [23:0] o_data;

  frame_windower dut (
    .clk (clk), .rst_n (rst_n), .i_valid (i_valid), .i_sample (i_sample),
    .o_valid (o_valid), .o_first (o_first), .o_last (o_last), .o_data (o_data),
    .o_frame_rdy (o_frame_rdy), .o_overrun (o_overrun)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int     n_vec = 0;
  int     n_bad = 0;
  int     hist [0:1023];
  int     nsent;
  int     last_edge;
  longint cap_data [0:1023];
  bit     cap_first [0:1023];
  bit     cap_last [0:1023];
  int     cap_cyc [0:1023];
  int     ncap = 0;
  int     n_rdy = 0;
  int     n_ovr = 0;
  int     rdy_cyc;
  int     lfsr;

  always @(negedge clk) begin
    if (o_valid && ncap < 1024) begin
      cap_data[ncap]  = longint'($signed(o_data));
      cap_first[ncap] = o_first;
      cap_last[ncap]  = o_last;
      cap_cyc[ncap]   = cyc;
      ncap++;
    end
    if (o_frame_rdy) begin
      n_rdy++;
      rdy_cyc = cyc;
    end
    if (o_overrun) n_ovr++;
  end

  function automatic longint wcoef(input int n);
    real r;
    r = 65536.0 * (0.54 - 0.46 * $cos(2.0 * 3.141592653589793 * n / 199.0));
    return longint'($rtoi(r + 0.5));
  endfunction

  function automatic longint wexp(input int x, input int n);
    longint p;
    p = longint'(x) * wcoef(n);
    return (p + 64) >>> 7;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; i_valid = 1'b0; i_sample = '0;
    repeat (3) @(negedge clk);
    chk("R1", "o_valid in reset", longint'(o_valid), 0);
    chk("R1", "o_frame_rdy in reset", longint'(o_frame_rdy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    nsent = 0; ncap = 0; n_rdy = 0; n_ovr = 0;
  endtask

  task automatic send(input int v);
    @(negedge clk);
    i_valid = 1'b1; i_sample = 12'(v);
    hist[nsent] = v; nsent++;
    last_edge = cyc + 1;
  endtask

  // R9: strobe low with changing junk on the data pins
  task automatic idle(input int m);
    for (int k = 0; k < m; k++) begin
      @(negedge clk);
      i_valid = 1'b0; i_sample = 12'hA5A ^ 12'(k * 7);
    end
  endtask

  function automatic int next_rand();
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
    return (lfsr & 12'hFFF) - 2048;
  endfunction

  task automatic check_frame(input string req, input int slot, input int f);
    for (int i = 0; i < 200; i++) begin
      int k;
      k = slot * 200 + i;
      chk(req, $sformatf("data f%0d n%0d", f, i), cap_data[k], wexp(hist[80 * f + i], i));
      chk("R6", $sformatf("first f%0d n%0d", f, i), longint'(cap_first[k]), longint'(i == 0));
      chk("R6", $sformatf("last f%0d n%0d", f, i), longint'(cap_last[k]), longint'(i == 199));
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "o_valid after reset", longint'(o_valid), 0);
    chk("R1", "o_first/o_last after reset", longint'(o_first | o_last), 0);
    chk("R1", "o_overrun after reset", longint'(o_overrun), 0);
    idle(20);
    chk("R1", "no output while idle", ncap, 0);
  endtask

  task automatic t_first_frame();
    do_reset();
    for (int k = 0; k < 199; k++) begin
      send(((k * 37) % 4096) - 2048);
      if (k % 5 == 4) idle(1);
    end
    idle(10);
    chk("R2", "no frame after 199 samples", n_rdy, 0);
    chk("R2", "no output after 199 samples", ncap, 0);
    send(1234);
    idle(260);
    chk("R2", "ready pulse count", n_rdy, 1);
    chk("R2", "ready pulse cycle", rdy_cyc, last_edge);
    chk("R5", "sample count", ncap, 200);
    chk("R5", "first output latency", cap_cyc[0] - last_edge, 2);
    for (int i = 1; i < 200; i++)
      chk("R5", $sformatf("consecutive n%0d", i), cap_cyc[i] - cap_cyc[0], i);
    check_frame("R4", 0, 0);
  endtask

  task automatic t_hop();
    do_reset();
    lfsr = 32'h1D3;
    for (int k = 0; k < 200; k++) send(next_rand());
    idle(260);
    for (int k = 0; k < 80; k++) begin
      send(next_rand());
      idle(2);
    end
    idle(260);
    for (int k = 0; k < 80; k++) send(next_rand());
    idle(260);
    chk("R3", "ready pulse count", n_rdy, 3);
    chk("R3", "output count", ncap, 600);
    chk("R9", "samples honoured with gaps", ncap, 600);
    check_frame("R3", 0, 0);
    check_frame("R3", 1, 1);
    check_frame("R9", 2, 2);
  endtask

  task automatic t_extremes();
    int pat [5];
    pat = '{2047, -2048, 0, -1, 1};
    do_reset();
    for (int k = 0; k < 200; k++) send(pat[k % 5]);
    idle(260);
    chk("R4", "output count", ncap, 200);
    check_frame("R4", 0, 0);
  endtask

  task automatic t_overrun();
    do_reset();
    lfsr = 32'h7A1;
    for (int k = 0; k < 280; k++) send(next_rand());
    idle(260);
    chk("R7", "overrun pulses", n_ovr, 1);
    chk("R7", "ready pulses", n_rdy, 2);
    chk("R7", "dropped frame not emitted", ncap, 200);
    check_frame("R7", 0, 0);
    for (int k = 0; k < 80; k++) send(next_rand());
    idle(260);
    chk("R7", "recovery output count", ncap, 400);
    chk("R7", "no further overrun", n_ovr, 1);
    check_frame("R7", 1, 2);
  endtask

  task automatic t_coincide(input int gap);
    do_reset();
    lfsr = 32'h3C5;
    for (int k = 0; k < 279; k++) send(next_rand());
    idle(gap);
    send(next_rand());
    idle(260);
    if (gap == 120) begin
      chk("R8", "no overrun on final issue cycle", n_ovr, 0);
      chk("R8", "two frames emitted", ncap, 400);
      chk("R8", "back to back", cap_cyc[200] - cap_cyc[199], 1);
      check_frame("R8", 0, 0);
      check_frame("R8", 1, 1);
    end else begin
      chk("R7", "overrun one cycle early", n_ovr, 1);
      chk("R7", "one frame emitted", ncap, 200);
      check_frame("R7", 0, 0);
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; i_valid = 1'b0; i_sample = '0;
    t_reset();
    t_first_frame();
    t_hop();
    t_extremes();
    t_overrun();
    t_coincide(120);
    t_coincide(119);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule